// File: doc/BRIEF.md
# Programmable-Logic Output Cell with Term-Driven Register

This block is one output cell of a sum-of-products programmable logic array. The cell evaluates eight product terms over a shared vector of array inputs. Four of them are control terms: register set, register clear, register clock and output enable. The other four are ORed into the cell's logic value. Each term is configured by a programming mask. A mask bit at 1 removes (blows) the connection to its literal. A mask bit at 0 keeps the literal in the AND.

The cell's register has no shared clock. It captures the sum when its own clock term rises, and its own set and clear terms act on it directly. The register also has a preload path that copies the pad value into it. Removing every literal from both the set and the clear term forces those terms permanently true. This turns the cell into a combinatorial output that bypasses the register. A per-cell polarity bit inverts the pad drive. The output buffer is enabled only when the enable term is true and an external active-low enable pin is low. The pad value is returned to the array as feedback.

The term clock is sampled by the chip's system clock `clk`. A rising edge of the term is detected between two successive system clock edges. Set, clear and preload are applied at the system clock edge. `rst` is the synchronous power-on clear.

Top module: `pld_async_macrocell`

## Requirements
- R1: Term t uses mask bits [t*2N +: 2N], where N is NUM_IN. Bit i of the slice connects input i true, and bit N+i connects input i complemented. A term is 1 exactly when every connected literal is 1. A term with no connected literal is 1. A term that connects both literals of one input is always 0.
- R2: Terms 4 to 7 are ORed to form the cell's logic value.
- R3: In registered mode the register takes the logic value at a system clock edge where the clock term (term 2) is 1 and was 0 at the previous edge. At every other edge without set, clear or preload, it holds.
- R4: While the set term (term 0) is 1 the register becomes 1 at the next edge. While the clear term (term 1) is 1 and set is 0, it becomes 0. Set wins over clear.
- R5: While `preload_n` is 0 the register takes `pad_in` at the next edge. This overrides set, clear and the clock term.
- R6: When every literal of both term 0 and term 1 is removed, the cell is combinatorial. The data value equals the logic value in the same cycle, with no clock term edge needed.
- R7: With `pol_invert` at 0, `pad_out` equals the data value. With `pol_invert` at 1, `pad_out` is the inverted data value.
- R8: `pad_oe` is 1 exactly when the enable term (term 3) is 1 and `oe_pin_n` is 0. It follows in the same cycle.
- R9: Either `oe_pin_n` at 1 or an enable term that is constantly false makes the cell input-only. Then `pad_oe` is 0 and `fb_out` equals `pad_in`.
- R10: While `pad_oe` is 1, `fb_out` equals `pad_out`. This carries the register state back to the array in registered mode.
- R11: `rst` clears the register to 0 at the next edge and wins over preload. With `pol_invert` at 1, `pad_out` then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the term clock |
| rst | input | 1 | Synchronous power-on clear, active high |
| arr_in | input | NUM_IN | Array input signals |
| term_mask | input | 8*2*NUM_IN | Programming masks, 1 = literal removed |
| oe_pin_n | input | 1 | External output enable, active low |
| preload_n | input | 1 | Register preload from the pad, active low |
| pad_in | input | 1 | Value present on the pad |
| pol_invert | input | 1 | Output polarity, 1 = inverted |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Feedback into the array |

## Verification
Term evaluation, polarity, output enable, feedback and the combinatorial bypass are all combinational. Their results are due in the same cycle as the stimulus. Register effects (term clock edge, set, clear, preload and power-on clear) are visible after the first system clock edge that samples the stimulus. Inputs change on the falling clock edge. Combinational results are checked 1 ns after that change, and registered results are checked 1 ns after the following rising edge. A behavioural model in the bench is advanced on every rising edge and compared with all three outputs at that same sampling point.

// File: rtl/pldmc_pkg.sv
package pldmc_pkg;

    localparam int NUM_CTRL  = 4;
    localparam int NUM_SUM   = 4;
    localparam int NUM_TERMS = NUM_CTRL + NUM_SUM;

    localparam int IDX_SET = 0;
    localparam int IDX_CLR = 1;
    localparam int IDX_CLK = 2;
    localparam int IDX_OE  = 3;
    localparam int IDX_SUM = 4;

    typedef enum logic {
        MODE_REG  = 1'b0,
        MODE_COMB = 1'b1
    } cell_mode_e;

    // control terms, LSB first: set, clear, clock, enable
    typedef struct packed {
        logic oe;
        logic clk;
        logic clr;
        logic set;
    } ctrl_terms_t;

    // next register value, priority preload > set > clear > clock edge
    function automatic logic reg_next(
        input logic preload_n,
        input logic pad,
        input logic set_t,
        input logic clr_t,
        input logic edge_seen,
        input logic d,
        input logic q
    );
        logic r;
        if (!preload_n)     r = pad;
        else if (set_t)     r = 1'b1;
        else if (clr_t)     r = 1'b0;
        else if (edge_seen) r = d;
        else                r = q;
        return r;
    endfunction

endpackage

// File: rtl/pldmc_term_array.sv
module pldmc_term_array
    import pldmc_pkg::*;
#(
    parameter int NUM_IN = 8,
    localparam int LIT_W  = 2 * NUM_IN,
    localparam int MASK_W = NUM_TERMS * LIT_W
) (
    input  logic [NUM_IN-1:0]    arr_in,
    input  logic [MASK_W-1:0]    term_mask,
    output logic [NUM_TERMS-1:0] terms
);

    logic [LIT_W-1:0] lits;
    assign lits = {~arr_in, arr_in};

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        // a removed literal reads as 1 inside the AND
        assign terms[t] = &(lits | term_mask[t*LIT_W +: LIT_W]);
    end

    always_comb begin
        for (int t = 0; t < NUM_TERMS; t++) begin
            // R1
            if (&term_mask[t*LIT_W +: LIT_W])
                empty_term_hi_chk: assert (terms[t]);
            for (int i = 0; i < NUM_IN; i++) begin
                // R1
                if (!term_mask[t*LIT_W + i] && !term_mask[t*LIT_W + NUM_IN + i])
                    contra_term_lo_chk: assert (!terms[t]);
            end
        end
    end

endmodule

// File: rtl/pldmc_term_reg.sv
module pldmc_term_reg
    import pldmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic preload_n,
    input  logic pad_in,
    input  logic set_t,
    input  logic clr_t,
    input  logic clk_t,
    input  logic d,
    output logic q
);

    logic clk_t_prev;
    logic rise;

    assign rise = clk_t && !clk_t_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= 1'b0;
            clk_t_prev <= 1'b1;
        end else begin
            q          <= reg_next(preload_n, pad_in, set_t, clr_t, rise, d, q);
            clk_t_prev <= clk_t;
        end
    end

    // R11
    por_clear_chk: assert property (@(posedge clk) rst |=> !q);

    // R5
    preload_load_chk: assert property (@(posedge clk) disable iff (rst)
        !preload_n |=> q == $past(pad_in));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        preload_n && set_t |=> q);

    // R3
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        preload_n && !set_t && !clr_t && !rise |=> $stable(q));

endmodule

// File: rtl/pldmc_out_ctl.sv
module pldmc_out_ctl
    import pldmc_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       sum_val,
    input  logic       q,
    input  logic       pol_invert,
    input  logic       oe_t,
    input  logic       oe_pin_n,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       fb_out
);

    logic data;

    always_comb begin
        data    = (mode == MODE_COMB) ? sum_val : q;
        pad_out = pol_invert ? ~data : data;
        pad_oe  = oe_t & ~oe_pin_n;
        fb_out  = pad_oe ? pad_out : pad_in;
    end

    always_comb begin
        // R9
        if (oe_pin_n == 1'b1)
            pin_disables_chk: assert (!pad_oe);
        // R10
        if (pad_oe == 1'b1)
            fb_tracks_drive_chk: assert (fb_out == pad_out);
        // R9
        if (pad_oe == 1'b0)
            fb_tracks_pad_chk: assert (fb_out == pad_in);
    end

endmodule

// File: rtl/pld_async_macrocell.sv
module pld_async_macrocell
    import pldmc_pkg::*;
#(
    parameter int NUM_IN = 8,
    localparam int LIT_W  = 2 * NUM_IN,
    localparam int MASK_W = NUM_TERMS * LIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] arr_in,
    input  logic [MASK_W-1:0] term_mask,
    input  logic              oe_pin_n,
    input  logic              preload_n,
    input  logic              pad_in,
    input  logic              pol_invert,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb_out
);

    logic [NUM_TERMS-1:0] terms;
    ctrl_terms_t          ctrl;
    logic                 sum_val;
    logic                 q;
    cell_mode_e           mode;

    pldmc_term_array #(.NUM_IN(NUM_IN)) u_array (
        .arr_in    (arr_in),
        .term_mask (term_mask),
        .terms     (terms)
    );

    assign ctrl    = ctrl_terms_t'(terms[NUM_CTRL-1:0]);
    assign sum_val = |terms[NUM_TERMS-1:IDX_SUM];

    // both async terms with every literal removed => bypass the register
    assign mode = (&term_mask[IDX_SET*LIT_W +: LIT_W] && &term_mask[IDX_CLR*LIT_W +: LIT_W])
                  ? MODE_COMB : MODE_REG;

    pldmc_term_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .preload_n (preload_n),
        .pad_in    (pad_in),
        .set_t     (ctrl.set),
        .clr_t     (ctrl.clr),
        .clk_t     (ctrl.clk),
        .d         (sum_val),
        .q         (q)
    );

    pldmc_out_ctl u_out (
        .mode       (mode),
        .sum_val    (sum_val),
        .q          (q),
        .pol_invert (pol_invert),
        .oe_t       (ctrl.oe),
        .oe_pin_n   (oe_pin_n),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .fb_out     (fb_out)
    );

endmodule

// File: tb/pld_async_macrocell_tb.sv
`timescale 1ns/1ps
module pld_async_macrocell_tb_top;

    localparam int NI = 8;
    localparam int LW = 2 * NI;

    logic            clk = 1'b0;
    logic            rst;
    logic [NI-1:0]   arr_in;
    logic [8*LW-1:0] tmask;
    logic            oe_pin_n, preload_n, pad_in, pol_invert;
    logic            pad_out, pad_oe, fb_out;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit armed    = 0;

    bit m_q, m_prev;

    always #2.5 clk = ~clk;

    pld_async_macrocell #(.NUM_IN(NI)) dut_i (
        .clk(clk), .rst(rst), .arr_in(arr_in), .term_mask(tmask),
        .oe_pin_n(oe_pin_n), .preload_n(preload_n), .pad_in(pad_in),
        .pol_invert(pol_invert), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    // behavioural term value: 0 if any kept literal disagrees with its input
    function automatic bit tval(int t);
        for (int i = 0; i < NI; i++) begin
            if (tmask[t*LW + i] == 1'b0 && arr_in[i] == 1'b0) return 1'b0;
            if (tmask[t*LW + NI + i] == 1'b0 && arr_in[i] == 1'b1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit comb_cfg();
        return (tmask[0 +: LW] == '1) && (tmask[LW +: LW] == '1);
    endfunction

    function automatic bit m_sum();
        return tval(4) || tval(5) || tval(6) || tval(7);
    endfunction

    function automatic bit exp_out();
        bit d;
        d = comb_cfg() ? m_sum() : m_q;
        return pol_invert ? !d : d;
    endfunction

    function automatic bit exp_oe();
        return tval(3) && !oe_pin_n;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference register, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_q    <= 1'b0;
            m_prev <= 1'b1;
        end else begin
            if (!preload_n)                m_q <= pad_in;
            else if (tval(0))              m_q <= 1'b1;
            else if (tval(1))              m_q <= 1'b0;
            else if (tval(2) && !m_prev)   m_q <= m_sum();
            m_prev <= tval(2);
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (armed) begin
            chk(pad_out, exp_out(), "R7 model pad_out");
            chk(pad_oe, exp_oe(), "R8 model pad_oe");
            chk(fb_out, exp_oe() ? exp_out() : pad_in, "R10 model fb_out");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drv();
        @(negedge clk);
    endtask

    task automatic t_hi(int t);
        tmask[t*LW +: LW] = '1;
    endtask

    task automatic t_lo(int t);
        tmask[t*LW +: LW] = '0;
    endtask

    task automatic t_lit(int t, int i);
        tmask[t*LW +: LW] = '1;
        tmask[t*LW + i]   = 1'b0;
    endtask

    task automatic t_and2(int t, int i, int j);
        tmask[t*LW +: LW] = '1;
        tmask[t*LW + i]   = 1'b0;
        tmask[t*LW + j]   = 1'b0;
    endtask

    initial begin
        rst = 1'b1; arr_in = '0; tmask = '0; oe_pin_n = 1'b0;
        preload_n = 1'b1; pad_in = 1'b0; pol_invert = 1'b1;
        repeat (3) tick();
        drv(); rst = 1'b0; t_hi(3); armed = 1;
        tick();
        chk(pad_out, 1'b1, "R11 active-low output after power-up");
        chk(pad_oe, 1'b1, "R8 enable term true, pin low");

        // registered: clock=in0, term4=in1, term5=in2&in3
        drv(); pol_invert = 1'b0; t_lit(2, 0); t_lit(4, 1); t_and2(5, 2, 3); arr_in = 8'h00;
        tick(); chk(pad_out, 1'b0, "R3 idle");
        drv(); arr_in = 8'h02; tick(); chk(pad_out, 1'b0, "R3 no clock edge holds");
        drv(); arr_in = 8'h03; tick(); chk(pad_out, 1'b1, "R3 capture on clock term rise");
        drv(); arr_in = 8'h01; tick(); chk(pad_out, 1'b1, "R3 no recapture while high");
        drv(); arr_in = 8'h00; tick(); chk(pad_out, 1'b1, "R3 hold on fall");
        drv(); arr_in = 8'h01; tick(); chk(pad_out, 1'b0, "R3 capture zero");
        drv(); arr_in = 8'h0C; tick();
        drv(); arr_in = 8'h0D; tick(); chk(pad_out, 1'b1, "R2 two-literal term in sum");
        drv(); arr_in = 8'h04; tick();
        drv(); arr_in = 8'h05; tick(); chk(pad_out, 1'b0, "R2 partial AND gives zero");

        // set = in4, clear = in5
        drv(); t_lit(0, 4); t_lit(1, 5); arr_in = 8'h10;
        tick(); chk(pad_out, 1'b1, "R4 set");
        drv(); arr_in = 8'h30; tick(); chk(pad_out, 1'b1, "R4 set wins over clear");
        drv(); arr_in = 8'h20; tick(); chk(pad_out, 1'b0, "R4 clear");
        drv(); arr_in = 8'h10; tick();
        drv(); arr_in = 8'h00; tick(); chk(pad_out, 1'b1, "R4 hold after set released");

        // preload
        drv(); arr_in = 8'h20; preload_n = 1'b0; pad_in = 1'b1;
        tick(); chk(pad_out, 1'b1, "R5 preload over clear");
        drv(); preload_n = 1'b1; tick(); chk(pad_out, 1'b0, "R4 clear after preload ends");
        drv(); preload_n = 1'b0; pad_in = 1'b0; arr_in = 8'h11;
        tick(); chk(pad_out, 1'b0, "R5 preload over set and clock");
        drv(); preload_n = 1'b1; arr_in = 8'h00; tick();
        chk(pad_out, 1'b0, "R5 preloaded state held");
        chk(fb_out, 1'b0, "R10 feedback carries register");
        drv(); pol_invert = 1'b1; #1;
        chk(pad_out, 1'b1, "R7 inverted polarity");
        chk(fb_out, 1'b1, "R10 feedback follows drive");
        drv(); pol_invert = 1'b0;

        // combinatorial bypass
        drv(); t_hi(0); t_hi(1); arr_in = 8'h02; #1;
        chk(pad_out, 1'b1, "R6 combinatorial follows sum at once");
        drv(); arr_in = 8'h00; #1;
        chk(pad_out, 1'b0, "R6 combinatorial falls at once");
        drv(); arr_in = 8'h0C; #1;
        chk(pad_out, 1'b1, "R6 combinatorial two-literal term");

        // input-only
        drv(); oe_pin_n = 1'b1; pad_in = 1'b0; #1;
        chk(pad_oe, 1'b0, "R9 pin high disables");
        chk(fb_out, 1'b0, "R9 feedback is pad");
        drv(); pad_in = 1'b1; #1;
        chk(fb_out, 1'b1, "R9 feedback is pad high");
        drv(); oe_pin_n = 1'b0; t_and2(3, 0, NI); arr_in = 8'h01; #1;
        chk(pad_oe, 1'b0, "R1 contradictory enable term false");
        drv(); arr_in = 8'h00; #1;
        chk(pad_oe, 1'b0, "R9 constant-false enable term");
        chk(fb_out, 1'b1, "R9 feedback from pad");

        // enable term = in6
        drv(); t_lit(3, 6); arr_in = 8'h40; #1;
        chk(pad_oe, 1'b1, "R8 enable on");
        drv(); arr_in = 8'h00; #1;
        chk(pad_oe, 1'b0, "R8 enable term low");
        drv(); arr_in = 8'h40; oe_pin_n = 1'b1; #1;
        chk(pad_oe, 1'b0, "R8 pin gates term");
        drv(); oe_pin_n = 1'b0;

        // reset wins over preload
        drv(); t_lo(0); t_lo(1); preload_n = 1'b0; pad_in = 1'b1; rst = 1'b1;
        tick(); chk(pad_out, 1'b0, "R11 reset over preload");
        drv(); rst = 1'b0; preload_n = 1'b1; pad_in = 1'b0;
        tick(); chk(pad_out, 1'b0, "R11 cleared after reset");
        drv(); arr_in = 8'h00; tick();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule